// File: doc/BRIEF.md
# Gradient-Direction Edge Thinning Unit

This block thins edges in a stream of gradient data. Each pixel of a square block arrives in raster order as a gradient magnitude plus the signed horizontal and vertical gradient components. Two row memories hold the two previous rows of magnitudes, so the full 3x3 neighbourhood of a centre pixel is available in a single cycle. The gradient components sort each centre into one of four direction sectors: horizontal, vertical, or one of two diagonals. The sector picks the two neighbours that lie across the edge. The centre keeps its magnitude only when it is a local maximum along that line. Otherwise it becomes zero.

Each block is processed on its own and no data passes between blocks. Every pixel on the outer ring of a block comes out as zero. The output keeps raster order, so a histogram stage or a hysteresis stage can follow it directly. Both sides use a valid/ready handshake. Once the last pixel of a block has been taken, the block closes its input and emits the remaining outputs on its own. A one-cycle start pulse aborts a partial block and re-aligns the row and column tracking.

Top module: `nms_thin`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each block of BLK×BLK accepted pixels produces exactly BLK×BLK outputs, in raster order (index = row·BLK + column).
- R3: An output pixel in row 0, row BLK-1, column 0 or column BLK-1 has magnitude 0.
- R4: With ax=|gx| and ay=|gy| of the centre, the sector is horizontal when 128·ay ≤ 53·ax, and the compared neighbours are then west (earlier) and east (later).
- R5: When R4 does not apply and 128·ay > 309·ax, the sector is vertical, and the compared neighbours are north (earlier) and south (later).
- R6: Otherwise the sector is diagonal. If gx and gy have the same sign bit, the neighbours are north-west (earlier) and south-east (later). If the sign bits differ, they are north-east (earlier) and south-west (later).
- R7: Ties are broken by raster order. The centre must be strictly greater than the earlier neighbour and greater than or equal to the later one.
- R8: A centre that passes the R7 test outputs its own magnitude. A centre that fails it outputs 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_mag` and `out_valid` hold and `in_ready` is 0.
- R10: A `blk_start` pulse drops any pending output, holds `in_ready` at 0 in that cycle, and makes the next accepted pixel row 0, column 0.
- R11: After the last pixel of a block is accepted, `in_ready` stays 0 until the final output of that block has been loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start | input | 1 | One-cycle pulse that restarts block tracking |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel accepted this cycle when high with in_valid |
| in_mag | input | MW | Gradient magnitude |
| in_gx | input | GW | Signed horizontal gradient |
| in_gy | input | GW | Signed vertical gradient |
| out_valid | output | 1 | Thinned pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_mag | output | MW | Thinned magnitude (0 when suppressed or on the border) |

## Verification
The bench builds the unit with BLK=6, MW=8 and GW=8. A 6×6 block has 16 interior centres and 20 border pixels, so many short blocks cover every sector, every tie case, the row wrap and the flush tail within a few thousand cycles. An 8-bit gradient also allows the value -128, which tests the absolute-value path at its widest point. Random output stalls and input gaps stress the hold and closed-input rules, and an aborted partial block tests the restart.

// File: rtl/nms_pkg.sv
`timescale 1ns/1ps
// Shared types for the edge-thinning unit.
// Assumes: sector encoding is internal; nothing outside the unit decodes it.
package nms_pkg;

    // Direction sector of the gradient at a centre pixel
    typedef enum logic [1:0] {
        SEC_HORZ  = 2'd0,
        SEC_VERT  = 2'd1,
        SEC_DSAME = 2'd2,
        SEC_DOPP  = 2'd3
    } sector_t;

endpackage

// File: rtl/nms_linebuf.sv
`timescale 1ns/1ps
// One row of delay storage addressed by column.
// Reads are combinational and return the value written one row earlier at
// the same column. The new value is written on the same edge.
// Assumes: contents are not reset; stale words only reach border centres.
module nms_linebuf #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0] mem [DEPTH];

    // Store the incoming word at the current column
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end

    assign dout = mem[addr];

endmodule

// File: rtl/nms_dir_sel.sv
`timescale 1ns/1ps
// Direction quantiser, neighbour selector and local-maximum compare.
// The sector comes from |gx| and |gy| against the constants 53/128 and
// 309/128, built from shifts and adds. Ties use raster order: the centre
// must beat the earlier neighbour strictly and the later one or equal.
// Assumes: purely combinational; the caller registers the result.
module nms_dir_sel
    import nms_pkg::*;
#(
    parameter int MW = 8,
    parameter int GW = 10
) (
    input  logic signed [GW-1:0] gx,
    input  logic signed [GW-1:0] gy,
    input  logic [MW-1:0]        ctr,
    input  logic [MW-1:0]        nw,
    input  logic [MW-1:0]        n,
    input  logic [MW-1:0]        ne,
    input  logic [MW-1:0]        w,
    input  logic [MW-1:0]        e,
    input  logic [MW-1:0]        sw,
    input  logic [MW-1:0]        s,
    input  logic [MW-1:0]        se,
    output logic [MW-1:0]        thin
);

    localparam int PW = GW + 9;

    logic [GW-1:0] ax, ay;
    logic [PW-1:0] axw, ay128, ax53, ax309;
    sector_t       sector;
    logic [MW-1:0] nb_early, nb_late;

    // Absolute values, widened for the scaled comparisons
    always_comb begin
        ax    = gx[GW-1] ? $unsigned(-gx) : $unsigned(gx);
        ay    = gy[GW-1] ? $unsigned(-gy) : $unsigned(gy);
        axw   = PW'(ax);
        ay128 = PW'(ay) << 7;
        ax53  = (axw << 5) + (axw << 4) + (axw << 2) + axw;
        ax309 = (axw << 8) + (axw << 5) + (axw << 4) + (axw << 2) + axw;
    end

    // Sector decision from the two scaled thresholds and the sign bits
    always_comb begin
        if (ay128 <= ax53)
            sector = SEC_HORZ;
        else if (ay128 > ax309)
            sector = SEC_VERT;
        else if (gx[GW-1] == gy[GW-1])
            sector = SEC_DSAME;
        else
            sector = SEC_DOPP;
    end

    // Route the across-edge pair, earlier-in-raster neighbour first
    always_comb begin
        unique case (sector)
            SEC_HORZ:  begin nb_early = w;  nb_late = e;  end
            SEC_VERT:  begin nb_early = n;  nb_late = s;  end
            SEC_DSAME: begin nb_early = nw; nb_late = se; end
            default:   begin nb_early = ne; nb_late = sw; end
        endcase
    end

    // Keep the centre only when it is the local maximum under the tie rule
    assign thin = ((ctr > nb_early) && (ctr >= nb_late)) ? ctr : '0;

endmodule

// File: rtl/nms_ctrl.sv
`timescale 1ns/1ps
// Block sequencing for the thinning unit.
// Tracks the input position and the output position inside the block.
// It decides when the window holds a full centre, and after the last input
// it runs a self-timed drain of the trailing border outputs.
// Assumes: BLK >= 3; the output register lives in the parent.
module nms_ctrl #(
    parameter int BLK = 64,
    localparam int CW = $clog2(BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start,
    input  logic          in_valid,
    input  logic          out_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          in_fire,
    output logic          out_load,
    output logic          out_border,
    output logic [CW-1:0] in_col
);

    localparam logic [CW-1:0] LAST = CW'(BLK - 1);

    logic [CW-1:0] in_row, out_row, out_col;
    logic          drain;
    logic          can_load, primed, in_last, out_last;

    // Handshake and window-readiness decode
    always_comb begin
        can_load   = !out_valid || out_ready;
        in_ready   = can_load && !drain && !blk_start;
        in_fire    = in_valid && in_ready;
        primed     = (in_row != '0) && !((in_row == CW'(1)) && (in_col == '0));
        out_load   = !blk_start && can_load && (drain || (in_fire && primed));
        in_last    = (in_row == LAST) && (in_col == LAST);
        out_last   = (out_row == LAST) && (out_col == LAST);
        out_border = (out_row == '0) || (out_row == LAST) ||
                     (out_col == '0) || (out_col == LAST);
    end

    // Position counters and the drain flag
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start) begin
            in_row  <= '0;
            in_col  <= '0;
            out_row <= '0;
            out_col <= '0;
            drain   <= 1'b0;
        end else begin
            if (in_fire) begin
                if (in_col == LAST) begin
                    in_col <= '0;
                    in_row <= (in_row == LAST) ? '0 : in_row + 1'b1;
                end else begin
                    in_col <= in_col + 1'b1;
                end
                if (in_last) drain <= 1'b1;
            end
            if (out_load) begin
                if (out_col == LAST) begin
                    out_col <= '0;
                    out_row <= (out_row == LAST) ? '0 : out_row + 1'b1;
                end else begin
                    out_col <= out_col + 1'b1;
                end
                if (out_last) drain <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nms_thin.sv
`timescale 1ns/1ps
// Edge-thinning unit: a 3x3 window of magnitudes built from two row
// memories and two column registers, a direction-driven neighbour compare,
// and one output register with valid/ready.
// Latency: the centre (r-1, c-1) is decided when pixel (r, c) is accepted
// and appears on the output one cycle later.
// Assumes: blocks of BLK x BLK pixels in raster order, BLK >= 3.
module nms_thin #(
    parameter int BLK = 64,
    parameter int MW  = 8,
    parameter int GW  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_start,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [MW-1:0]        in_mag,
    input  logic signed [GW-1:0] in_gx,
    input  logic signed [GW-1:0] in_gy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [MW-1:0]        out_mag
);

    localparam int CW    = $clog2(BLK);
    localparam int NROWS = 2;

    logic          in_fire, out_load, out_border;
    logic [CW-1:0] col;
    logic [MW-1:0] row_tap [NROWS];
    logic [2*GW-1:0] grad_row;
    logic [MW-1:0] c0_top, c0_mid, c0_bot, c1_top, c1_mid, c1_bot;
    logic signed [GW-1:0] cgx, cgy;
    logic [MW-1:0] thin_mag;

    nms_ctrl #(.BLK(BLK)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_start  (blk_start),
        .in_valid   (in_valid),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .in_fire    (in_fire),
        .out_load   (out_load),
        .out_border (out_border),
        .in_col     (col)
    );

    // Chain of magnitude row memories: tap 0 is one row back, tap 1 is two
    for (genvar i = 0; i < NROWS; i++) begin : g_row
        logic [MW-1:0] row_din;
        if (i == 0) begin : g_first
            assign row_din = in_mag;
        end else begin : g_next
            assign row_din = row_tap[i-1];
        end
        nms_linebuf #(.W(MW), .DEPTH(BLK)) u_lb (
            .clk  (clk),
            .we   (in_fire),
            .addr (col),
            .din  (row_din),
            .dout (row_tap[i])
        );
    end

    // Gradient components of the previous row, aligned with the centre row
    nms_linebuf #(.W(2*GW), .DEPTH(BLK)) u_grad_lb (
        .clk  (clk),
        .we   (in_fire),
        .addr (col),
        .din  ({in_gx, in_gy}),
        .dout (grad_row)
    );

    // Shift the two stored window columns and latch the next centre gradient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_top <= '0; c0_mid <= '0; c0_bot <= '0;
            c1_top <= '0; c1_mid <= '0; c1_bot <= '0;
            cgx    <= '0; cgy    <= '0;
        end else if (in_fire) begin
            c1_top <= c0_top;
            c1_mid <= c0_mid;
            c1_bot <= c0_bot;
            c0_top <= row_tap[1];
            c0_mid <= row_tap[0];
            c0_bot <= in_mag;
            cgx    <= $signed(grad_row[2*GW-1:GW]);
            cgy    <= $signed(grad_row[GW-1:0]);
        end
    end

    nms_dir_sel #(.MW(MW), .GW(GW)) u_sel (
        .gx   (cgx),
        .gy   (cgy),
        .ctr  (c0_mid),
        .nw   (c1_top),
        .n    (c0_top),
        .ne   (row_tap[1]),
        .w    (c1_mid),
        .e    (row_tap[0]),
        .sw   (c1_bot),
        .s    (c0_bot),
        .se   (in_mag),
        .thin (thin_mag)
    );

    // Output register: load a decided pixel, hold under stall, clear on take
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start) begin
            out_valid <= 1'b0;
            out_mag   <= '0;
        end else if (out_load) begin
            out_valid <= 1'b1;
            out_mag   <= out_border ? '0 : thin_mag;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/nms_thin_chk.sv
`timescale 1ns/1ps
// Property checker for the edge-thinning unit, attached with bind.
// It keeps its own count of accepted inputs and taken outputs, built only
// from the port handshakes.
module nms_thin_chk #(
    parameter int BLK = 64,
    parameter int MW  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          blk_start,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [MW-1:0] out_mag
);

    localparam int TOTAL = BLK * BLK;
    localparam int NW    = $clog2(TOTAL + 1) + 1;
    localparam int CW    = $clog2(BLK);
    localparam logic [CW-1:0] LAST = CW'(BLK - 1);

    logic [NW-1:0] acc_cnt;
    logic [CW-1:0] o_row, o_col;
    logic          o_fire, i_fire, o_last;

    assign o_fire = out_valid && out_ready;
    assign i_fire = in_valid && in_ready;
    assign o_last = (o_row == LAST) && (o_col == LAST);

    // Count accepted inputs and track the position of the next output taken
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start) begin
            acc_cnt <= '0;
            o_row   <= '0;
            o_col   <= '0;
        end else begin
            acc_cnt <= ((o_fire && o_last) ? '0 : acc_cnt) + NW'(i_fire);
            if (o_fire) begin
                if (o_col == LAST) begin
                    o_col <= '0;
                    o_row <= (o_row == LAST) ? '0 : o_row + 1'b1;
                end else begin
                    o_col <= o_col + 1'b1;
                end
            end
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !blk_start) |=> (out_valid && $stable(out_mag)));

    // R9
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !out_valid);

    // R10
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> !in_ready);

    // R3
    border_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((o_row == '0) || (o_row == LAST) ||
                       (o_col == '0) || (o_col == LAST))) |-> (out_mag == '0));

    // R11
    drain_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_cnt == NW'(TOTAL)) && !o_last) |-> !in_ready);

    // R2
    accept_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= NW'(TOTAL));

endmodule

bind nms_thin nms_thin_chk #(.BLK(BLK), .MW(MW)) u_nms_thin_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_mag   (out_mag)
);

// File: tb/nms_thin_test.sv
`timescale 1ns/1ps
// Self-checking bench for the edge-thinning unit: seeded random blocks in
// several gradient shapes, random stalls and gaps, an aborted partial block.
module nms_thin_test;

    localparam int BLK = 6;
    localparam int MW  = 8;
    localparam int GW  = 8;
    localparam int N   = BLK * BLK;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 blk_start = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [MW-1:0]        in_mag = '0;
    logic signed [GW-1:0] in_gx = '0;
    logic signed [GW-1:0] in_gy = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [MW-1:0]        out_mag;

    int checks = 0;
    int errors = 0;
    int stall_pct = 0;
    int got_n = 0;
    int got [N];
    int pm  [N];
    int pgx [N];
    int pgy [N];
    bit prev_stall = 1'b0;
    int prev_mag = 0;

    nms_thin #(.BLK(BLK), .MW(MW), .GW(GW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mag    (in_mag),
        .in_gx     (in_gx),
        .in_gy     (in_gy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_mag   (out_mag)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int mat(input int r, input int c);
        return pm[r*BLK + c];
    endfunction

    // Expected neighbours for pixel k: returns sector 0..3, fills early/late
    function automatic int pick(input int k, output int early, output int late);
        int r = k / BLK;
        int c = k % BLK;
        int ax = absi(pgx[k]);
        int ay = absi(pgy[k]);
        if (128*ay <= 53*ax) begin
            early = mat(r, c-1); late = mat(r, c+1); return 0;
        end
        if (128*ay > 309*ax) begin
            early = mat(r-1, c); late = mat(r+1, c); return 1;
        end
        if ((pgx[k] < 0) == (pgy[k] < 0)) begin
            early = mat(r-1, c-1); late = mat(r+1, c+1); return 2;
        end
        early = mat(r-1, c+1); late = mat(r+1, c-1); return 3;
    endfunction

    function automatic bit on_border(input int k);
        int r = k / BLK;
        int c = k % BLK;
        return (r == 0) || (r == BLK-1) || (c == 0) || (c == BLK-1);
    endfunction

    // Output capture and hold check, sampled between edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stall && !blk_start)
                chk(out_valid && (int'(out_mag) == prev_mag), "R9 hold", int'(out_mag), prev_mag);
            if (out_valid && out_ready) begin
                if (got_n < N) got[got_n] = int'(out_mag);
                got_n++;
            end
            prev_stall = out_valid && !out_ready;
            prev_mag   = int'(out_mag);
        end
    end

    always @(negedge clk) out_ready = (($urandom % 100) >= stall_pct);

    task automatic gen_block(input int mode);
        for (int i = 0; i < N; i++) begin
            int sx = ($urandom % 2) ? 1 : -1;
            int sy = ($urandom % 2) ? 1 : -1;
            int a  = 4 + ($urandom % 124);
            pm[i]  = $urandom % 256;
            pgx[i] = int'($signed(8'($urandom)));
            pgy[i] = int'($signed(8'($urandom)));
            case (mode)
                1: begin pgx[i] = sx*a; pgy[i] = ($urandom % 2) ? sy*(a/4) : 0; end
                2: begin pgy[i] = sy*a; pgx[i] = ($urandom % 2) ? 0 : sx*(a/4); end
                3: begin pgx[i] = sx*(50 + $urandom % 51); pgy[i] = sy*(50 + $urandom % 51); end
                4: pm[i] = 10 + ($urandom % 3);
                5: begin pm[i] = 20; pgx[i] = sx*a; pgy[i] = 0; end
                6: begin pgx[i] = -128; pgy[i] = ($urandom % 2) ? -128 : 127; end
                default: ;
            endcase
        end
    endtask

    task automatic feed(input int count, input int gap_pct);
        for (int i = 0; i < count; i++) begin
            bit done = 1'b0;
            while (!done) begin
                @(negedge clk);
                if (($urandom % 100) < gap_pct) begin
                    in_valid = 1'b0;
                end else begin
                    in_valid = 1'b1;
                    in_mag   = MW'(pm[i]);
                    in_gx    = GW'(pgx[i]);
                    in_gy    = GW'(pgy[i]);
                    #0.5;
                    if (in_ready) done = 1'b1;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_block(input int mode, input int gap_pct);
        int wd = 0;
        gen_block(mode);
        got_n = 0;
        feed(N, gap_pct);
        while (got_n < N && wd < 2000) begin
            #0.5;
            // R11: input closed while the block drains
            if (got_n < N-1) chk(!in_ready, "R11 drain", int'(in_ready), 0);
            @(negedge clk);
            wd++;
        end
        repeat (3) @(negedge clk);
        chk(got_n == N, "R2 count", got_n, N);
        for (int k = 0; k < N && k < got_n; k++) begin
            int e_nb, l_nb, sec, exp;
            string tag;
            if (on_border(k)) begin
                exp = 0; tag = "R3 border";
            end else begin
                sec = pick(k, e_nb, l_nb);
                exp = (pm[k] > e_nb && pm[k] >= l_nb) ? pm[k] : 0;
                if (pm[k] == e_nb || pm[k] == l_nb) tag = "R7 tie/R8";
                else if (sec == 0) tag = "R4 horz/R8";
                else if (sec == 1) tag = "R5 vert/R8";
                else tag = "R6 diag/R8";
            end
            chk(got[k] == exp, tag, got[k], exp);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        // R1
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        stall_pct = 0;  run_block(0, 0);
        stall_pct = 30; run_block(1, 10);
        stall_pct = 30; run_block(2, 10);
        stall_pct = 50; run_block(3, 20);
        stall_pct = 20; run_block(4, 0);
        stall_pct = 0;  run_block(5, 0);
        stall_pct = 40; run_block(6, 30);

        // R10: abort a partial block, then run a full one
        stall_pct = 0;
        gen_block(0);
        feed(10, 0);
        repeat (4) @(negedge clk);
        blk_start = 1'b1;
        #0.5;
        chk(!in_ready, "R10 gate", int'(in_ready), 0);
        @(negedge clk);
        blk_start = 1'b0;
        #0.5;
        chk(!out_valid, "R10 drop", int'(out_valid), 0);
        run_block(0, 10);

        for (int b = 0; b < 8; b++) begin
            stall_pct = 40;
            run_block(b % 7, 25);
        end
        finish_run();
    end

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

endmodule